// File: doc/BRIEF.md
# MSI Pending Register Bank

This unit terminates posted message-signalled interrupt writes and records each one as a pending bit. The storage is organised as 16 groups. Each group holds 8 index registers, and each index register holds 16 vector bits, for 2048 vectors in all. The write address selects the group and the index register. The write data selects the bit to set.

For every group the unit derives an 8-bit summary word with one bit per index register. It also drives one interrupt line per group, which stays high while any bit in that group is pending. Software drains the bank through a simple read port. Reading an index register returns its contents and clears them in the same cycle. Reading a summary word has no side effect. Malformed writes are dropped and raise a sticky error flag.

Top module: `msi_pend_unit`

## Requirements
- R1: An MSI write to byte offset (n << 19) + (x << 16) + any low offset below 0x10000, with n in 0..15, x in 0..7 and data d in 0..15, sets bit d of index register (n,x). Other bits are left unchanged.
- R2: A read request is registered, so `rd_data` shows the result in the cycle after `rd_valid`. A read of index register (n,x), at the same offsets as R1, returns its 16 bits and clears them. In a cycle after no request, `rd_data` is zero.
- R3: The summary word of group n is read at offset 0x800000 + (n << 16). Its bit x is 1 exactly when index register (n,x) holds at least one set bit. Bits above 7 read as zero.
- R4: `grp_irq[n]` is high exactly when the summary word of group n is nonzero.
- R5: If a write and a read-to-clear hit the same index register in the same cycle:
  - the read returns the contents from before the write;
  - afterwards the register holds only the newly written bit.
- R6: An MSI write with a data value of 16 or more changes no pending bit and sets `err_flag`.
- R7: An MSI write whose offset is 0x800000 or above (the summary window or beyond) changes no pending bit and sets `err_flag`.
- R8: Reading a summary word changes no state. A read at an offset of 0x900000 or above returns zero.
- R9: A synchronous reset clears all pending bits, `err_flag` and all `grp_irq` lines.
- R10: Once every index register has been read with no write in between, all summary words read zero and all interrupt lines are low.
- R11: `err_flag`, once set, stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| msi_valid | input | 1 | An MSI write is presented this cycle |
| msi_addr | input | 24 | Byte offset of the MSI write within the block |
| msi_data | input | 32 | MSI write data; selects the vector bit |
| rd_valid | input | 1 | A register read is requested this cycle |
| rd_addr | input | 24 | Byte offset of the register read |
| rd_data | output | 16 | Read result, one cycle after the request |
| grp_irq | output | 16 | One interrupt line per group |
| err_flag | output | 1 | Sticky flag for dropped MSI writes |

## Verification
Some rules are checked by assertions on every cycle:
- a write sets the addressed bit;
- a read-to-clear empties the register, except for a bit written in the same cycle, which survives;
- summaries stay stable in a group that sees no write or clear;
- the error flag is sticky, and it rises after a bad data value or a bad address;
- `rd_data` returns to zero after an idle cycle.

Other behaviour can only be shown by the bench's scenarios, because it depends on the address map as a whole:
- the exact offset of every index register and summary word, which the bench covers with a full sweep of all 128 registers;
- the summary bits falling one by one as the bank is drained;
- reset clearing a populated bank;
- reads beyond the map returning zero.

// File: rtl/msi_pend_pkg.sv
package msi_pend_pkg;
    // Default geometry of the pending bank
    localparam int unsigned DEF_GROUPS  = 16;
    localparam int unsigned DEF_IDX     = 8;
    localparam int unsigned DEF_VEC     = 16;
    // Each register occupies a 2**DEF_WIN_LSB byte window
    localparam int unsigned DEF_WIN_LSB = 16;
    localparam int unsigned DATA_W      = 32;

    function automatic int unsigned width_of(input int unsigned count);
        return (count <= 1) ? 1 : $clog2(count);
    endfunction
endpackage

// File: rtl/msi_pend_decode.sv
module msi_pend_decode #(
    parameter int unsigned GROUPS  = 16,
    parameter int unsigned IDX     = 8,
    parameter int unsigned GRP_W   = 4,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned WIN_LSB = 16,
    parameter int unsigned ADDR_W  = 24
) (
    input  logic [ADDR_W-1:WIN_LSB] addr_hi,
    output logic                    hit_ir,
    output logic                    hit_sum,
    output logic [GRP_W-1:0]        ir_grp,
    output logic [IDX_W-1:0]        ir_idx,
    output logic [GRP_W-1:0]        sum_grp
);
    localparam logic [GRP_W:0] GRP_LIM = GROUPS[GRP_W:0];
    localparam logic [IDX_W:0] IDX_LIM = IDX[IDX_W:0];

    always_comb begin
        ir_idx  = addr_hi[WIN_LSB +: IDX_W];
        ir_grp  = addr_hi[WIN_LSB+IDX_W +: GRP_W];
        sum_grp = addr_hi[WIN_LSB +: GRP_W];
        // Index window: top bit clear, group and index in range
        hit_ir  = !addr_hi[ADDR_W-1]
                  && ({1'b0, ir_grp} < GRP_LIM)
                  && ({1'b0, ir_idx} < IDX_LIM);
        // Summary window: top bit set, bits between group field and top bit zero
        hit_sum = addr_hi[ADDR_W-1]
                  && (addr_hi[ADDR_W-2 : WIN_LSB+GRP_W] == '0)
                  && ({1'b0, sum_grp} < GRP_LIM);
    end
endmodule

// File: rtl/msi_pend_group.sv
module msi_pend_group #(
    parameter int unsigned IDX   = 8,
    parameter int unsigned VEC   = 16,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned VEC_W = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          set_en,
    input  logic [IDX_W-1:0]              set_idx,
    input  logic [VEC_W-1:0]              set_bit,
    input  logic                          clr_en,
    input  logic [IDX_W-1:0]              clr_idx,
    output logic [IDX-1:0][VEC-1:0]       ir_val,
    output logic [IDX-1:0]                summary,
    output logic                          irq
);
    typedef struct packed {
        logic [IDX-1:0][VEC-1:0] ir;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clear first, then set: a same-cycle write survives the clear
        if (clr_en) st_d.ir[clr_idx] = '0;
        if (set_en) st_d.ir[set_idx][set_bit] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar i = 0; i < IDX; i++) begin : g_sum
        assign summary[i] = |st_q.ir[i];
    end

    assign ir_val = st_q.ir;
    assign irq    = |summary;

    // R1: an accepted write leaves its bit set
    a_r1_bit_set: assert property (@(posedge clk) disable iff (rst)
        set_en |=> st_q.ir[$past(set_idx)][$past(set_bit)]);

    // R2: a read-to-clear with no colliding write empties the register
    a_r2_cleared: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> (st_q.ir[$past(clr_idx)] == '0));

    // R5: on collision only the new bit remains
    a_r5_write_survives: assert property (@(posedge clk) disable iff (rst)
        (clr_en && set_en && set_idx == clr_idx)
        |=> (st_q.ir[$past(clr_idx)] == (VEC'(1) << $past(set_bit))));

    // R3: no write and no clear keeps the summary stable
    a_r3_summary_stable: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(summary));
endmodule

// File: rtl/msi_pend_unit.sv
module msi_pend_unit
    import msi_pend_pkg::*;
#(
    parameter int unsigned GROUPS  = DEF_GROUPS,
    parameter int unsigned IDX     = DEF_IDX,
    parameter int unsigned VEC     = DEF_VEC,
    parameter int unsigned WIN_LSB = DEF_WIN_LSB,
    localparam int unsigned GRP_W  = width_of(GROUPS),
    localparam int unsigned IDX_W  = width_of(IDX),
    localparam int unsigned VEC_W  = width_of(VEC),
    localparam int unsigned ADDR_W = WIN_LSB + IDX_W + GRP_W + 1,
    localparam int unsigned RD_W   = (VEC > IDX) ? VEC : IDX
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 msi_valid,
    input  logic [ADDR_W-1:0]    msi_addr,
    input  logic [DATA_W-1:0]    msi_data,
    input  logic                 rd_valid,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [RD_W-1:0]      rd_data,
    output logic [GROUPS-1:0]    grp_irq,
    output logic                 err_flag
);
    localparam logic [DATA_W-1:0] DATA_LIM = DATA_W'(VEC);

    typedef struct packed {
        logic [RD_W-1:0] rd;
        logic            err;
    } top_st_t;

    top_st_t st_d, st_q;

    // Offset bits inside a register window carry no meaning
    logic unused_low;
    assign unused_low = ^{msi_addr[WIN_LSB-1:0], rd_addr[WIN_LSB-1:0]};

    logic             w_hit_ir, w_hit_sum;
    logic [GRP_W-1:0] w_grp, w_sum_grp;
    logic [IDX_W-1:0] w_idx;
    logic             r_hit_ir, r_hit_sum;
    logic [GRP_W-1:0] r_grp, r_sum_grp;
    logic [IDX_W-1:0] r_idx;
    logic             data_ok, w_accept;
    logic             unused_wsum;

    assign unused_wsum = ^{w_hit_sum, w_sum_grp};

    msi_pend_decode #(
        .GROUPS(GROUPS), .IDX(IDX), .GRP_W(GRP_W), .IDX_W(IDX_W),
        .WIN_LSB(WIN_LSB), .ADDR_W(ADDR_W)
    ) u_wdec (
        .addr_hi(msi_addr[ADDR_W-1:WIN_LSB]),
        .hit_ir(w_hit_ir), .hit_sum(w_hit_sum),
        .ir_grp(w_grp), .ir_idx(w_idx), .sum_grp(w_sum_grp)
    );

    msi_pend_decode #(
        .GROUPS(GROUPS), .IDX(IDX), .GRP_W(GRP_W), .IDX_W(IDX_W),
        .WIN_LSB(WIN_LSB), .ADDR_W(ADDR_W)
    ) u_rdec (
        .addr_hi(rd_addr[ADDR_W-1:WIN_LSB]),
        .hit_ir(r_hit_ir), .hit_sum(r_hit_sum),
        .ir_grp(r_grp), .ir_idx(r_idx), .sum_grp(r_sum_grp)
    );

    assign data_ok  = (msi_data < DATA_LIM);
    assign w_accept = msi_valid && w_hit_ir && data_ok;

    logic [GROUPS-1:0][IDX-1:0][VEC-1:0] ir_all;
    logic [GROUPS-1:0][IDX-1:0]          sum_all;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        localparam logic [GRP_W-1:0] GID = GRP_W'(g);
        msi_pend_group #(
            .IDX(IDX), .VEC(VEC), .IDX_W(IDX_W), .VEC_W(VEC_W)
        ) u_grp (
            .clk     (clk),
            .rst     (rst),
            .set_en  (w_accept && (w_grp == GID)),
            .set_idx (w_idx),
            .set_bit (msi_data[VEC_W-1:0]),
            .clr_en  (rd_valid && r_hit_ir && (r_grp == GID)),
            .clr_idx (r_idx),
            .ir_val  (ir_all[g]),
            .summary (sum_all[g]),
            .irq     (grp_irq[g])
        );
    end

    always_comb begin
        st_d = st_q;
        st_d.rd = '0;
        if (rd_valid) begin
            if (r_hit_ir)       st_d.rd = RD_W'(ir_all[r_grp][r_idx]);
            else if (r_hit_sum) st_d.rd = RD_W'(sum_all[r_sum_grp]);
        end
        if (msi_valid && !w_accept) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_data  = st_q.rd;
    assign err_flag = st_q.err;

    // R11: error flag never falls outside reset
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R6: out-of-range data raises the flag
    a_r6_bad_data: assert property (@(posedge clk) disable iff (rst)
        (msi_valid && msi_data >= DATA_LIM) |=> err_flag);

    // R7: a write at or above the summary window raises the flag
    a_r7_bad_addr: assert property (@(posedge clk) disable iff (rst)
        (msi_valid && msi_addr[ADDR_W-1]) |=> err_flag);

    // R2: no request means zero read data next cycle
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> (rd_data == '0));
endmodule

// File: tb/msi_pend_unit_tb.sv
module msi_pend_unit_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msi_valid = 1'b0;
    logic [23:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        rd_valid = 1'b0;
    logic [23:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] grp_irq;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] model [16][8];

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_pend_unit dut_i (
        .clk(clk), .rst(rst),
        .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
        .grp_irq(grp_irq), .err_flag(err_flag)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: ran %0d cycles, expected at most %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [23:0] ir_off(int n, int x);
        return 24'((n << 19) + (x << 16));
    endfunction

    function automatic logic [23:0] sum_off(int n);
        return 24'(32'h800000 + (n << 16));
    endfunction

    function automatic logic [15:0] model_sum(int n);
        logic [15:0] s = '0;
        for (int x = 0; x < 8; x++) s[x] = (model[n][x] != 0);
        return s;
    endfunction

    function automatic logic [15:0] model_irq();
        logic [15:0] v = '0;
        for (int n = 0; n < 16; n++) v[n] = (model_sum(n) != 0);
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < 16; n++)
            for (int x = 0; x < 8; x++) model[n][x] = '0;
    endtask

    task automatic msi_wr(logic [23:0] a, logic [31:0] d);
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = a; msi_data = d;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic reg_rd(logic [23:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
        v = rd_data;
    endtask

    task automatic wr_and_rd(logic [23:0] wa, logic [31:0] wd, logic [23:0] ra,
                             output logic [15:0] v);
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = wa; msi_data = wd;
        rd_valid = 1'b1; rd_addr = ra;
        @(negedge clk);
        msi_valid = 1'b0; rd_valid = 1'b0;
        v = rd_data;
    endtask

    initial begin
        logic [15:0] v;
        do_reset();

        // R9: reset state
        chk("R9 irq after reset", 32'(grp_irq), 0);
        chk("R9 err after reset", 32'(err_flag), 0);
        for (int n = 0; n < 16; n++) begin
            reg_rd(sum_off(n), v);
            chk("R9 summary after reset", 32'(v), 0);
        end

        // R1: sweep two bits into every index register
        for (int n = 0; n < 16; n++)
            for (int x = 0; x < 8; x++) begin
                int d1 = (n * 3 + x) % 16;
                int d2 = (n + 2 * x + 5) % 16;
                msi_wr(ir_off(n, x) | 24'(n * 4 + x), 32'(d1));
                msi_wr(ir_off(n, x), 32'(d2));
                model[n][x] = model[n][x] | (16'(1) << d1) | (16'(1) << d2);
            end
        // R3 and R4: every summary full, every line high
        for (int n = 0; n < 16; n++) begin
            reg_rd(sum_off(n), v);
            chk("R3 summary after sweep", 32'(v), 32'(model_sum(n)));
        end
        chk("R4 irq after sweep", 32'(grp_irq), 32'(model_irq()));
        chk("R6 err clean after sweep", 32'(err_flag), 0);

        // R2 / R3 / R4: drain and watch summary bits fall
        for (int n = 0; n < 16; n++) begin
            for (int x = 0; x < 8; x++) begin
                reg_rd(ir_off(n, x), v);
                chk("R2 read returns contents", 32'(v), 32'(model[n][x]));
                model[n][x] = '0;
                reg_rd(sum_off(n), v);
                chk("R3 summary while draining", 32'(v), 32'(model_sum(n)));
            end
            chk("R4 irq after group drained", 32'(grp_irq), 32'(model_irq()));
        end
        // R10: everything empty after one read of each register
        for (int n = 0; n < 16; n++) begin
            reg_rd(sum_off(n), v);
            chk("R10 summary zero after drain", 32'(v), 0);
        end
        chk("R10 irq low after drain", 32'(grp_irq), 0);
        reg_rd(ir_off(3, 2), v);
        chk("R2 second read empty", 32'(v), 0);

        // R1: all 16 bits of one register, nonzero low offset
        for (int d = 0; d < 16; d++) msi_wr(ir_off(5, 3) | 24'h00ABCD, 32'(d));
        chk("R4 single group irq", 32'(grp_irq), 32'h0020);
        reg_rd(ir_off(5, 3), v);
        chk("R1 all bits set", 32'(v), 32'hFFFF);

        // R5: collision of write and read-to-clear
        msi_wr(ir_off(2, 4), 1);
        wr_and_rd(ir_off(2, 4), 7, ir_off(2, 4), v);
        chk("R5 read returns old contents", 32'(v), 32'h0002);
        reg_rd(ir_off(2, 4), v);
        chk("R5 new bit survives", 32'(v), 32'h0080);

        // R8: summary read has no side effect, beyond-map reads zero
        msi_wr(ir_off(9, 6), 12);
        reg_rd(sum_off(9), v);
        chk("R8 summary first read", 32'(v), 32'h0040);
        reg_rd(sum_off(9), v);
        chk("R8 summary second read", 32'(v), 32'h0040);
        reg_rd(24'h900000, v);
        chk("R8 beyond map reads zero", 32'(v), 0);
        reg_rd(24'hF30000, v);
        chk("R8 far beyond map reads zero", 32'(v), 0);
        reg_rd(ir_off(9, 6), v);
        chk("R8 index intact after summary reads", 32'(v), 32'h1000);

        // R6: bad data value ignored and flagged
        msi_wr(ir_off(0, 0), 16);
        chk("R6 err set by bad data", 32'(err_flag), 1);
        chk("R6 irq unchanged", 32'(grp_irq), 0);
        reg_rd(ir_off(0, 0), v);
        chk("R6 no bit set", 32'(v), 0);
        msi_wr(ir_off(1, 1), 32'h80000003);
        reg_rd(ir_off(1, 1), v);
        chk("R6 high data bits rejected", 32'(v), 0);

        // R11: flag stays set
        repeat (20) @(negedge clk);
        chk("R11 err still set", 32'(err_flag), 1);
        do_reset();
        chk("R9 err cleared by reset", 32'(err_flag), 0);

        // R7: writes to summary window and beyond are dropped
        msi_wr(sum_off(0), 1);
        chk("R7 err set by summary write", 32'(err_flag), 1);
        chk("R7 irq unchanged", 32'(grp_irq), 0);
        reg_rd(sum_off(0), v);
        chk("R7 summary unchanged", 32'(v), 0);
        msi_wr(24'hC00000, 2);
        chk("R7 irq unchanged by far write", 32'(grp_irq), 0);

        // R9: reset clears a populated bank
        do_reset();
        msi_wr(ir_off(15, 7), 15);
        msi_wr(ir_off(7, 0), 0);
        chk("R4 two lines high", 32'(grp_irq), 32'h8080);
        do_reset();
        chk("R9 irq cleared by reset", 32'(grp_irq), 0);
        reg_rd(ir_off(15, 7), v);
        chk("R9 bits cleared by reset", 32'(v), 0);
        chk("R2 idle read data zero", 32'(rd_data), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule